// File: doc/BRIEF.md
# Supervisor reset and watchdog controller

This block drives the system reset of a CPU supervisor. A supply-OK flag, already synchronised from an external comparator, tells it whether the supply sits above the trip point. Reset is asserted at once whenever that flag is low. Reset is released only after the flag has stayed high for a fixed delay. Any dip during that delay starts the wait again.

Once the system is running, a watchdog expects the host to prove it is alive through the sampled serial bus lines. The proof is a start condition, at least one clock low-then-high toggle, and then a stop condition. A 2-bit period select chooses one of three timeouts, or turns the watchdog off. A missed deadline produces a fixed-length reset pulse.

While reset is active, a bus-inhibit flag makes the serial interface drop any transfer in progress. A second flag tells the memory whether a nonvolatile cycle may continue: a write that was already busy when reset began may finish, but none may start. All durations count a millisecond tick made from the system clock, and the tick length is a parameter. The reset level is chosen at build time.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `supply_ok` is low, reset is active in the same cycle. From the first clock edge on, the controller stays in its hold state.
- R2: After `supply_ok` rises, reset stays active for `REL_MS` ticks (±1 tick) and is then released. A low cycle of `supply_ok` during the wait restarts the full delay.
- R3: A kick is a start (SDA falls while SCL stays high), then SCL low at least once, then a stop (SDA rises while SCL stays high). A start followed by a stop with no SCL low in between is not a kick.
- R4: `wd_sel` selects the watchdog period: 00 gives `WD_LONG_MS`, 01 gives `WD_MID_MS`, 10 gives `WD_SHORT_MS`, and 11 disables the watchdog.
- R5: When no kick arrives within the selected period, reset is asserted for `PULSE_MS` ticks (±1 tick) and then released.
- R6: `bus_inhibit` is high exactly when reset is active.
- R7: `nv_permit` is high while reset is inactive. During reset it stays high only while a nonvolatile cycle that was busy before reset began keeps `nv_busy` high. Once `nv_busy` has fallen during reset, `nv_permit` stays low.
- R8: With `RST_ACTIVE_LOW`=1, `rst_out` is 0 when reset is active. With 0, `rst_out` is 1 when reset is active.
- R9: The watchdog count restarts on every kick and on every release of reset, so a full period follows each reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous logic reset, active low |
| supply_ok | input | 1 | Synchronised comparator flag, high when the supply is above the trip point |
| wd_sel | input | 2 | Watchdog period select |
| scl | input | 1 | Sampled serial clock line |
| sda | input | 1 | Sampled serial data line |
| nv_busy | input | 1 | A nonvolatile write cycle is running |
| rst_out | output | 1 | System reset, level set by `RST_ACTIVE_LOW` |
| bus_inhibit | output | 1 | Abort and refuse serial transfers |
| nv_permit | output | 1 | A nonvolatile cycle may proceed |

## Verification
The hardest situations to reach are the ones where timing and bus patterns interact. One is a supply dip in the middle of a release delay. Another is a stream of start/stop pairs that looks busy but never lowers SCL, so it must not count as a kick. The bench produces these with directed bus-level tasks that move SDA and SCL in separate steps. It shortens the tick to four clocks so that whole periods fit in a few hundred cycles. The nonvolatile grace case needs `nv_busy` raised before the supply drops, then lowered and raised again while reset is still held.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        SQ_HOLD  = 2'd0,
        SQ_DELAY = 2'd1,
        SQ_RUN   = 2'd2,
        SQ_PULSE = 2'd3
    } seq_state_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sup_tick_gen.sv
module sup_tick_gen #(
    parameter int unsigned CYC_PER_TICK = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tg_t;

    tg_t d, q;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        if (q.cnt >= CW'(CYC_PER_TICK - 1)) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

    // R2
    tick_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.tick |-> (q.cnt == '0));
endmodule

// File: rtl/sup_kick_det.sv
module sup_kick_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    input  logic abort,
    output logic kick
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic armed;
        logic low_seen;
        logic kick;
    } kd_t;

    localparam kd_t KD_RST = '{scl_p: 1'b1, sda_p: 1'b1, armed: 1'b0, low_seen: 1'b0, kick: 1'b0};

    kd_t d, q;
    logic start_c, stop_c;

    always_comb begin
        start_c = q.scl_p & scl & q.sda_p & ~sda;
        stop_c  = q.scl_p & scl & ~q.sda_p & sda;
        d       = q;
        d.scl_p = scl;
        d.sda_p = sda;
        d.kick  = 1'b0;
        if (abort) begin
            d.armed    = 1'b0;
            d.low_seen = 1'b0;
        end else if (start_c) begin
            d.armed    = 1'b1;
            d.low_seen = 1'b0;
        end else if (stop_c) begin
            d.kick     = q.armed & q.low_seen;
            d.armed    = 1'b0;
            d.low_seen = 1'b0;
        end else if (q.armed && !scl) begin
            d.low_seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= KD_RST;
        else        q <= d;
    end

    assign kick = q.kick;

    // R3
    kick_needs_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.kick |-> ($past(q.armed) && $past(q.low_seen)));
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int unsigned WD_LONG_MS  = 1400,
    parameter int unsigned WD_MID_MS   = 600,
    parameter int unsigned WD_SHORT_MS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       kick,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       expire
);
    import sup_pkg::*;

    localparam int unsigned WMAX = umax(WD_LONG_MS, umax(WD_MID_MS, WD_SHORT_MS));
    localparam int unsigned WW   = $clog2(WMAX + 1);

    typedef struct packed {
        logic [WW-1:0] cnt;
        logic          exp;
    } wd_t;

    wd_t d, q;
    logic [WW-1:0] limit;
    logic          enabled;

    always_comb begin
        case (sel)
            2'b00:   limit = WW'(WD_LONG_MS);
            2'b01:   limit = WW'(WD_MID_MS);
            default: limit = WW'(WD_SHORT_MS);
        endcase
        enabled = (sel != 2'b11);
        d       = q;
        d.exp   = 1'b0;
        if (!run || kick || !enabled) begin
            d.cnt = '0;
        end else if (tick) begin
            if (q.cnt >= limit - 1'b1) begin
                d.cnt = '0;
                d.exp = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expire = q.exp;

    // R4
    wd_off_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.exp |-> ($past(sel) != 2'b11));

    // R9
    wd_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(kick) || !$past(run)) |-> (q.cnt == '0));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
    parameter int unsigned CYC_PER_TICK   = 50000,
    parameter int unsigned REL_MS         = 200,
    parameter int unsigned PULSE_MS       = 250,
    parameter int unsigned WD_LONG_MS     = 1400,
    parameter int unsigned WD_MID_MS      = 600,
    parameter int unsigned WD_SHORT_MS    = 200,
    parameter bit          RST_ACTIVE_LOW = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic [1:0] wd_sel,
    input  logic       scl,
    input  logic       sda,
    input  logic       nv_busy,
    output logic       rst_out,
    output logic       bus_inhibit,
    output logic       nv_permit
);
    import sup_pkg::*;

    localparam int unsigned SMAX = umax(REL_MS, PULSE_MS);
    localparam int unsigned SCW  = $clog2(SMAX + 1);

    typedef struct packed {
        seq_state_e     st;
        logic [SCW-1:0] cnt;
        logic           grace;
    } sq_t;

    sq_t  d, q;
    logic tick, kick, expire, rst_active, wd_run;

    sup_tick_gen #(.CYC_PER_TICK(CYC_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    sup_kick_det u_kick (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
        .abort(rst_active), .kick(kick)
    );

    sup_wdog #(
        .WD_LONG_MS(WD_LONG_MS), .WD_MID_MS(WD_MID_MS), .WD_SHORT_MS(WD_SHORT_MS)
    ) u_wdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
        .run(wd_run), .sel(wd_sel), .expire(expire)
    );

    assign rst_active  = (q.st != SQ_RUN) | ~supply_ok;
    assign wd_run      = (q.st == SQ_RUN) & supply_ok;
    assign bus_inhibit = rst_active;
    assign nv_permit   = ~rst_active | q.grace;
    assign rst_out     = RST_ACTIVE_LOW ? ~rst_active : rst_active;

    always_comb begin
        d = q;
        if (!rst_active) d.grace = nv_busy;
        else             d.grace = q.grace & nv_busy;

        case (q.st)
            SQ_HOLD: begin
                d.cnt = '0;
                if (supply_ok) d.st = SQ_DELAY;
            end
            SQ_DELAY: begin
                if (tick) begin
                    if (q.cnt == SCW'(REL_MS - 1)) begin
                        d.st  = SQ_RUN;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            SQ_RUN: begin
                d.cnt = '0;
                if (expire) d.st = SQ_PULSE;
            end
            default: begin
                if (tick) begin
                    if (q.cnt == SCW'(PULSE_MS - 1)) begin
                        d.st  = SQ_RUN;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
        endcase

        if (!supply_ok) begin
            d.st  = SQ_HOLD;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SQ_HOLD, cnt: '0, grace: 1'b0};
        else        q <= d;
    end

    // R1
    supply_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(supply_ok) |-> (q.st == SQ_HOLD));

    // R2
    release_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == SQ_DELAY && q.st == SQ_RUN) |->
            ($past(q.cnt) == SCW'(REL_MS - 1) && $past(tick)));

    // R5
    pulse_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_PULSE) |-> ($past(q.st) == SQ_RUN || $past(q.st) == SQ_PULSE));

    // R7
    nv_grace_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.grace) |-> $past(nv_busy));
endmodule

// File: tb/sup_reset_ctrl_bench.sv
module sup_reset_ctrl_bench;
    localparam int P     = 4;
    localparam int REL   = 20;
    localparam int PUL   = 25;
    localparam int WL    = 140;
    localparam int WM    = 60;
    localparam int WS    = 20;

    localparam logic [1:0] VSEL  [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    localparam int         VMS   [4] = '{WL, WM, WS, 0};
    localparam bit         VFIRE [4] = '{1'b1, 1'b1, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic [1:0] wd_sel = 2'b10;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic nv_busy = 1'b0;
    logic rst_lo, rst_hi, inh_lo, inh_hi, nvp_lo, nvp_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sup_reset_ctrl #(.CYC_PER_TICK(P), .REL_MS(REL), .PULSE_MS(PUL),
        .WD_LONG_MS(WL), .WD_MID_MS(WM), .WD_SHORT_MS(WS), .RST_ACTIVE_LOW(1'b1))
    u_sup_reset_ctrl (.clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_sel(wd_sel),
        .scl(scl), .sda(sda), .nv_busy(nv_busy), .rst_out(rst_lo),
        .bus_inhibit(inh_lo), .nv_permit(nvp_lo));

    sup_reset_ctrl #(.CYC_PER_TICK(P), .REL_MS(REL), .PULSE_MS(PUL),
        .WD_LONG_MS(WL), .WD_MID_MS(WM), .WD_SHORT_MS(WS), .RST_ACTIVE_LOW(1'b0))
    u_sup_reset_ctrl_hi (.clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_sel(wd_sel),
        .scl(scl), .sda(sda), .nv_busy(nv_busy), .rst_out(rst_hi),
        .bus_inhibit(inh_hi), .nv_permit(nvp_hi));

    function automatic bit active();
        return rst_lo === 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // cycles until reset goes inactive
    task automatic wait_rel(input int lim, output int n);
        n = 0;
        while (active() && n < lim) begin @(negedge clk); n++; end
    endtask

    // cycles until reset goes active
    task automatic wait_fire(input int lim, output int n);
        n = 0;
        while (!active() && n < lim) begin @(negedge clk); n++; end
    endtask

    task automatic power_up();
        int n;
        supply_ok = 1'b0;
        cyc(3);
        supply_ok = 1'b1;
        wait_rel(400, n);
    endtask

    task automatic kick_good();
        sda = 1'b0; cyc(3);
        scl = 1'b0; cyc(3);
        scl = 1'b1; cyc(3);
        sda = 1'b1; cyc(3);
    endtask

    task automatic kick_bad();
        sda = 1'b0; cyc(3);
        sda = 1'b1; cyc(9);
    endtask

    initial begin
        cyc(200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        cyc(3);
        rst_n = 1'b1;
        cyc(5);
        // R1 R6 R8: reset state with supply low
        chk(active(), "R1 reset at power-up", rst_lo, 0);
        chk(inh_lo === 1'b1, "R6 inhibit at power-up", inh_lo, 1);
        chk(rst_hi === 1'b1, "R8 active-high level", rst_hi, 1);

        // R2 release delay
        supply_ok = 1'b1;
        wait_rel(400, n);
        chk(n >= (REL-1)*P && n <= REL*P+3, "R2 release delay", n, REL*P);
        chk(inh_lo === 1'b0 && nvp_lo === 1'b1, "R6 R7 run outputs", inh_lo, 0);
        chk(rst_hi === 1'b0, "R8 inactive high level", rst_hi, 0);

        // R1 immediate, R2 restart on dip
        supply_ok = 1'b0; #1;
        chk(active(), "R1 immediate assert", rst_lo, 0);
        cyc(2);
        supply_ok = 1'b1;
        cyc(50);
        supply_ok = 1'b0; cyc(1);
        supply_ok = 1'b1;
        wait_rel(400, n);
        chk(n >= (REL-1)*P && n <= REL*P+3, "R2 delay restarts", n, REL*P);

        // R4 R5 period table
        for (int v = 0; v < 4; v++) begin
            wd_sel = VSEL[v];
            power_up();
            wait_fire(VFIRE[v] ? VMS[v]*P + 50 : 700, n);
            if (VFIRE[v])
                chk(n >= (VMS[v]-1)*P && n <= VMS[v]*P+3, "R4 R5 watchdog period", n, VMS[v]*P);
            else
                chk(!active(), "R4 watchdog off code", n, 700);
        end

        // R5 pulse length, R9 fresh period after pulse
        wd_sel = 2'b10;
        power_up();
        wait_fire(200, n);
        chk(inh_lo === 1'b1 && rst_hi === 1'b1, "R6 R8 during pulse", inh_lo, 1);
        wait_rel(400, n);
        chk(n >= (PUL-1)*P && n <= PUL*P+3, "R5 pulse length", n, PUL*P);
        wait_fire(200, n);
        chk(n >= (WS-1)*P && n <= WS*P+3, "R9 fresh period", n, WS*P);

        // R3 R9 good kicks hold off the watchdog
        power_up();
        n = 0;
        for (int k = 0; k < 10; k++) begin
            cyc(28);
            kick_good();
            if (active()) n++;
        end
        chk(n == 0 && !active(), "R3 R9 kicks keep run", n, 0);

        // R3 kicks without SCL low do not count
        power_up();
        n = 0;
        for (int k = 0; k < 10 && !active(); k++) begin
            cyc(28);
            kick_bad();
            n += 40;
        end
        chk(active(), "R3 bad kick ignored", n, WS*P);

        // R7 nonvolatile grace
        wd_sel = 2'b11;
        power_up();
        nv_busy = 1'b1;
        cyc(3);
        supply_ok = 1'b0; #1;
        chk(nvp_lo === 1'b1, "R7 busy write finishes", nvp_lo, 1);
        cyc(3);
        chk(nvp_lo === 1'b1, "R7 grace held", nvp_lo, 1);
        nv_busy = 1'b0;
        cyc(2);
        chk(nvp_lo === 1'b0, "R7 grace ends", nvp_lo, 0);
        nv_busy = 1'b1;
        cyc(2);
        chk(nvp_lo === 1'b0 && nvp_hi === 1'b0, "R7 no new write", nvp_lo, 0);
        nv_busy = 1'b0;
        supply_ok = 1'b1;
        wait_rel(400, n);
        chk(!active(), "R2 final release", n, REL*P);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule